// File: doc/BRIEF.md
# Down-Counting Interval Timer Channel

This block is a single interval timer channel. It holds a 32-bit down-counter, a 32-bit reload constant and a 16-bit control register. A prescaler outside the block supplies a bank of count-enable taps. A clock-select field in the control register picks one tap. Each enabled cycle moves the counter down by one. When an enabled cycle finds the counter at zero, the counter reloads from the constant and an underflow flag is latched.

The flag drives a level interrupt while the interrupt-enable bit is set. Software clears the flag by writing 0 to it. Writing 1 to the flag does nothing. If an underflow and a clearing write land in the same cycle, the underflow wins, so no event is lost. The power-on reset and the manual reset act identically on the block. There is no standby input, so the register contents survive anything except those two resets.

Top module: `dtimer_channel`

## Requirements
- R1: After power-on reset, the control register (address 0) reads 0x0000, the constant (address 1) reads 0xFFFFFFFF, the counter (address 2) reads 0xFFFFFFFF and `irq` is 0.
- R2: Control bits 2:0 select the count enable. Codes 0 to 4 select `tapCe[code]` (divide by 4, 16, 64, 256 and 1024 respectively). Codes 5 to 7 stop counting. On each selected enable with a nonzero counter, the counter drops by exactly one.
- R3: A selected enable that finds the counter at 0 loads the counter from the constant and sets the underflow flag (control bit 8) at the same clock edge.
- R4: A control write with bit 8 = 0 clears the underflow flag. A control write with bit 8 = 1 leaves the flag unchanged.
- R5: When an underflow and a flag-clearing control write happen in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when the underflow flag and the enable bit (control bit 5) are both 1. `irq` stays high until one of them is cleared.
- R7: Control bits 15:9 and 7:6, and read bits 31:16 at address 0, always read 0 whatever was written. Control bits 5:0 read back the last value written to them. Bits 4:3 are plain storage with no effect on counting.
- R8: The address map is 0 for control, 1 for constant and 2 for counter. Address 3 reads 0, and a write to it changes nothing. A counter write takes priority over counting in the same cycle and raises no underflow.
- R9: The manual reset alone puts the block into the same state as the power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPowerN | input | 1 | Power-on reset, active low, asynchronous |
| rstManualN | input | 1 | Manual reset, active low, asynchronous |
| regAddr | input | 2 | Register select: 0 control, 1 constant, 2 counter |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data (control uses bits 15:0) |
| regRdData | output | 32 | Combinational read data of the selected register |
| tapCe | input | 5 | Prescaled count-enable pulses, one per divisor |
| irq | output | 1 | Level underflow interrupt |

## Verification
The checker watches several rules on every cycle:
- a decrement by one per selected enable;
- a frozen counter under a stop code;
- a reload from the previous constant, and a set flag, after each underflow;
- a flag that a write of 1 cannot move;
- a held interrupt level;
- zeros in every reserved read position.

Other behaviours only show up through the bench's scenarios, which it compares against a reference model:
- the clear-versus-set race;
- the exact tap each select code picks;
- the dead address;
- counter-write priority;
- the equivalence of the two resets.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CONST = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;

  // Strobes from the control side into the datapath
  typedef struct packed {
    logic wrConst;
    logic wrCount;
    logic countEn;
  } dpStrobe_t;

endpackage

// File: rtl/dtimer_ctrl.sv
module dtimer_ctrl
  import dtimer_pkg::*;
#(
  parameter int CTRL_W   = 16,
  parameter int NUM_TAPS = 5,
  parameter int SEL_W    = 3,
  parameter int LOW_W    = 6,
  parameter int FLAG_BIT = 8,
  parameter int IE_BIT   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CTRL_W-1:0] wrCtrlData,
  input  logic [NUM_TAPS-1:0] tapCe,
  input  logic              underflow,
  output dpStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              irq
);

  logic [LOW_W-1:0]    lowQ;
  logic                flagQ;
  logic                wrCtrl;
  logic [NUM_TAPS-1:0] tapHit;

  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);

  // One comparator per tap; unmatched codes give no enable
  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapHit[g] = (lowQ[SEL_W-1:0] == SEL_W'(g)) && tapCe[g];
  end

  always_comb begin
    strobe         = '0;
    strobe.countEn = |tapHit;
    strobe.wrConst = regWrEn && (regAddr == ADDR_CONST);
    strobe.wrCount = regWrEn && (regAddr == ADDR_COUNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ  <= '0;
      flagQ <= 1'b0;
    end else begin
      if (wrCtrl) lowQ <= wrCtrlData[LOW_W-1:0];
      if (underflow)                          flagQ <= 1'b1;
      else if (wrCtrl && !wrCtrlData[FLAG_BIT]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    ctrlQ              = '0;
    ctrlQ[LOW_W-1:0]   = lowQ;
    ctrlQ[FLAG_BIT]    = flagQ;
  end

  assign irq = flagQ && lowQ[IE_BIT];

endmodule

// File: rtl/dtimer_datapath.sv
module dtimer_datapath
  import dtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] constQ,
  output logic             underflow
);

  localparam logic [CNT_W-1:0] RESET_VAL = '1;

  logic atZero;

  assign atZero    = (cntQ == '0);
  assign underflow = strobe.countEn && !strobe.wrCount && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= RESET_VAL;
      constQ <= RESET_VAL;
    end else begin
      if (strobe.wrConst) constQ <= wrData;
      if (strobe.wrCount)      cntQ <= wrData;
      else if (strobe.countEn) cntQ <= atZero ? constQ : cntQ - 1'b1;
    end
  end

endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtimer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int CTRL_W   = 16,
  parameter int NUM_TAPS = 5
) (
  input  logic                clk,
  input  logic                rstPowerN,
  input  logic                rstManualN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [CNT_W-1:0]    regWrData,
  output logic [CNT_W-1:0]    regRdData,
  input  logic [NUM_TAPS-1:0] tapCe,
  output logic                irq
);

  localparam int SEL_W = $clog2(NUM_TAPS + 1);

  logic             rstN;
  dpStrobe_t        strobe;
  logic [CTRL_W-1:0] ctrlQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] constQ;
  logic             underflow;

  assign rstN = rstPowerN && rstManualN;

  dtimer_ctrl #(
    .CTRL_W(CTRL_W), .NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W),
    .LOW_W(6), .FLAG_BIT(8), .IE_BIT(5)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrCtrlData(regWrData[CTRL_W-1:0]), .tapCe(tapCe),
    .underflow(underflow), .strobe(strobe), .ctrlQ(ctrlQ), .irq(irq)
  );

  dtimer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .cntQ(cntQ), .constQ(constQ), .underflow(underflow)
  );

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:  regRdData = CNT_W'(ctrlQ);
      ADDR_CONST: regRdData = constQ;
      ADDR_COUNT: regRdData = cntQ;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dtimer_checker.sv
module dtimer_checker
  import dtimer_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int CTRL_W   = 16,
  parameter int NUM_TAPS = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWrEn,
  input logic [CNT_W-1:0]    regWrData,
  input logic [CNT_W-1:0]    regRdData,
  input logic                irq,
  input dpStrobe_t           strobe,
  input logic [CTRL_W-1:0]   ctrlQ,
  input logic [CNT_W-1:0]    cntQ,
  input logic [CNT_W-1:0]    constQ,
  input logic                underflow
);

  logic ctrlWr;
  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.wrCount && cntQ != '0) |=> (cntQ == $past(cntQ) - 1'b1));

  a_r2_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (32'(ctrlQ[2:0]) >= NUM_TAPS && !strobe.wrCount) |=> $stable(cntQ));

  a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> (cntQ == $past(constQ)));

  a_r3_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> ctrlQ[8]);

  a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[8] && !underflow) |=> $stable(ctrlQ[8]));

  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !ctrlWr) |=> irq);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> (regRdData[CNT_W-1:9] == '0 && regRdData[7:6] == 2'b00));

endmodule

bind dtimer_channel dtimer_checker #(
  .CNT_W(CNT_W), .CTRL_W(CTRL_W), .NUM_TAPS(NUM_TAPS)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
  .strobe(strobe), .ctrlQ(ctrlQ), .cntQ(cntQ), .constQ(constQ),
  .underflow(underflow)
);

// File: tb/dtimer_channel_tb.sv
module dtimer_channel_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstPowerN = 1'b0;
  logic        rstManualN = 1'b1;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  tapCe = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [5:0]  mLow;
  logic        mFlag;
  logic [31:0] mCnt;
  logic [31:0] mConst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtimer_channel u_dut (
    .clk(clk), .rstPowerN(rstPowerN), .rstManualN(rstManualN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tapCe(tapCe), .irq(irq)
  );

  function automatic logic [31:0] modelRead(input logic [1:0] a);
    case (a)
      2'd0:    return {23'd0, mFlag, 2'b00, mLow};
      2'd1:    return mConst;
      2'd2:    return mCnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string defTag(input logic [1:0] a);
    case (a)
      2'd0:    return "R7";
      2'd2:    return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic modelReset();
    mLow = '0; mFlag = 1'b0; mCnt = '1; mConst = '1;
  endtask

  task automatic modelUpdate();
    logic ce, wrC, wrK, wrT, uf;
    ce  = (mLow[2:0] < 3'd5) ? tapCe[mLow[2:0]] : 1'b0;
    wrT = regWrEn && regAddr == 2'd0;
    wrK = regWrEn && regAddr == 2'd1;
    wrC = regWrEn && regAddr == 2'd2;
    uf  = ce && !wrC && mCnt == 32'd0;
    if (wrC)     mCnt = regWrData;
    else if (ce) mCnt = (mCnt == 32'd0) ? mConst : mCnt - 32'd1;
    if (wrK) mConst = regWrData;
    mFlag = uf || (mFlag && !(wrT && !regWrData[8]));
    if (wrT) mLow = regWrData[5:0];
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic we, input logic [31:0] wd,
                      input logic [4:0] taps, input string tag);
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = wd; tapCe = taps;
    #1;
    check((tag == "") ? defTag(a) : tag, regRdData, modelRead(a));
    check("R6", {31'd0, irq}, {31'd0, mFlag && mLow[5]});
    @(posedge clk);
    modelUpdate();
  endtask

  task automatic doReset(input bit manual);
    @(negedge clk);
    regWrEn = 1'b0; tapCe = '0;
    if (manual) rstManualN = 1'b0; else rstPowerN = 1'b0;
    @(negedge clk);
    rstManualN = 1'b1; rstPowerN = 1'b1;
    modelReset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired got %0d expected 0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1742);
    modelReset();
    doReset(1'b0);
    // R1 reset values
    step(2'd0, 1'b0, 0, 5'd0, "R1");
    step(2'd1, 1'b0, 0, 5'd0, "R1");
    step(2'd2, 1'b0, 0, 5'd0, "R1");
    // enable irq, sel 0, small constant and counter
    step(2'd0, 1'b1, 32'h20, 5'd0, "R7");
    step(2'd1, 1'b1, 32'd2, 5'd0, "R8");
    step(2'd2, 1'b1, 32'd1, 5'd0, "R8");
    // R2 count down, R3 underflow and reload
    step(2'd2, 1'b0, 0, 5'b00001, "R2");
    step(2'd0, 1'b0, 0, 5'b00001, "R3");
    step(2'd0, 1'b0, 0, 5'd0, "R3");
    step(2'd2, 1'b0, 0, 5'd0, "R3");
    // R4 write one keeps, write zero clears
    step(2'd0, 1'b1, 32'h120, 5'd0, "R4");
    step(2'd0, 1'b0, 0, 5'd0, "R4");
    step(2'd0, 1'b1, 32'h20, 5'd0, "R4");
    step(2'd0, 1'b0, 0, 5'd0, "R4");
    // R5 set beats clear
    step(2'd2, 1'b1, 32'd0, 5'd0, "R8");
    step(2'd0, 1'b1, 32'h20, 5'b00001, "R5");
    step(2'd0, 1'b0, 0, 5'd0, "R5");
    // R7 reserved bits, sel 7 stops
    step(2'd0, 1'b1, 32'hFFFF_FFFF, 5'd0, "R7");
    step(2'd0, 1'b0, 0, 5'h1F, "R7");
    step(2'd2, 1'b0, 0, 5'h1F, "R2");
    step(2'd2, 1'b0, 0, 5'h1F, "R2");
    // R2 sel 4 uses only the last tap
    step(2'd0, 1'b1, 32'h24, 5'd0, "R2");
    step(2'd2, 1'b1, 32'd5, 5'd0, "R2");
    step(2'd2, 1'b0, 0, 5'b01111, "R2");
    step(2'd2, 1'b0, 0, 5'b10000, "R2");
    step(2'd2, 1'b0, 0, 5'd0, "R2");
    // R8 dead address, counter write priority
    step(2'd3, 1'b1, 32'hDEAD_BEEF, 5'd0, "R8");
    step(2'd1, 1'b0, 0, 5'd0, "R8");
    step(2'd2, 1'b1, 32'd0, 5'd0, "R8");
    step(2'd2, 1'b1, 32'd7, 5'b10000, "R8");
    step(2'd2, 1'b0, 0, 5'd0, "R8");
    // R9 manual reset
    doReset(1'b1);
    step(2'd0, 1'b0, 0, 5'd0, "R9");
    step(2'd1, 1'b0, 0, 5'd0, "R9");
    step(2'd2, 1'b0, 0, 5'd0, "R9");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  a;
      logic        we;
      logic [31:0] wd;
      a  = 2'($urandom % 4);
      we = ($urandom % 4) == 0;
      wd = (a == 2'd0) ? $urandom : ($urandom % 8);
      if ($urandom % 600 == 0) doReset($urandom % 2 == 0);
      step(a, we, wd, 5'($urandom), "");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule